// File: doc/BRIEF.md
# Clock Output Gating and Stop Controller

This block decides, for each of a parameterised number of clock outputs (eight by default), whether that output runs, holds a fixed driven level, or floats. It also selects whether the outputs run at full rate or at half rate. Each output is modelled digitally as a true line, a complement line and a driver enable. While an output runs, its true line follows a phase signal that the block derives from the reference clock `clk`. At full rate the true line changes on every cycle. At half rate each level lasts two cycles.

The inputs are board-level control pins and configuration fields written through a serial management interface. The pins are per-output enables, a stop request, a power-down request, a half-rate select and one polarity pin that flips the sense of the enable, stop and power-down pins. The configuration fields are per-output enable bits, a per-output stop mask, two bits that choose whether a stopped output floats or is driven, and a full-rate bit. All pins are taken to be synchronous to `clk`.

An output changes mode only on an edge where its phase is low. Entering or leaving a stop therefore never cuts a clock pulse short. The configuration fields are captured one cycle after they are presented, and they are frozen while power-down is active.

Top module: `clk_stop_ctrl`

## Requirements
- R1: With `pol_inv`=0, `oe_pin` bits are active high and `stop_n`/`pdn_n` are active low. With `pol_inv`=1, all three are taken with the opposite sense.
- R2: An output is enabled only when both its pin enable and its `cfg_out_en` bit are active. A disabled output, when not powered down, floats: `clk_oe`=0 and both lines 0.
- R3: While a stop is requested, outputs whose `cfg_stop_mask` bit is 1 leave the running state. Outputs whose mask bit is 0 keep toggling.
- R4: A stopped output is driven (`clk_oe`=1, `clk_t`=1, `clk_c`=0) when its float bit is 0, and floats (all three 0) when it is 1. `cfg_stop_float` applies to stop and `cfg_pdn_float` applies to power-down.
- R5: An output's mode (run, driven hold, float) changes only on a clock edge at which the running phase is low.
- R6: Power-down overrides stop and enable. It affects every output regardless of mask or enable. Once it has been held long enough, no true line changes.
- R7: Configuration inputs take effect one cycle after they are presented. While power-down is active they are ignored, and the values captured before power-down are kept.
- R8: A running output has `clk_c` = not `clk_t`. At full rate `clk_t` toggles every cycle. Half rate is selected when `half_n`=0 or `cfg_full_rate`=0, and then each level lasts two cycles.
- R9: During reset every output floats. The captured configuration resets to: all enabled, mask 0, both float bits 0, full rate 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oe_pin | input | N_OUT | Per-output enable pins |
| stop_n | input | 1 | Stop request pin (active low at `pol_inv`=0) |
| pdn_n | input | 1 | Power-down request pin (active low at `pol_inv`=0) |
| pol_inv | input | 1 | Inverts the sense of `oe_pin`, `stop_n` and `pdn_n` |
| half_n | input | 1 | Half-rate select pin, active low |
| cfg_out_en | input | N_OUT | Per-output enable bits, 1 = enabled |
| cfg_stop_mask | input | N_OUT | 1 = output stops on a stop request |
| cfg_stop_float | input | 1 | 1 = a stopped output floats, 0 = it is driven |
| cfg_pdn_float | input | 1 | 1 = a powered-down output floats, 0 = it is driven |
| cfg_full_rate | input | 1 | 0 = half rate |
| clk_t | output | N_OUT | True clock lines |
| clk_c | output | N_OUT | Complement clock lines |
| clk_oe | output | N_OUT | Per-pair driver enable |

## Verification
The bench targets these corner cases:
- A stop arriving in half-rate mode while the phase is high. A design that switched at once would emit a runt high pulse, and the true line would jump a cycle early.
- Configuration writes made during power-down. A design without the freeze would change the powered-down level, or come out of power-down with the new mask in force.
- Power-down landing on disabled and unmasked outputs. A design that gave stop or enable priority would leave some outputs floating or toggling.
- The polarity pin flipped with the pins re-driven to match. A design that inverted only some of the pins would stop or disable outputs that should run.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_FLOAT = 2'd2
    } lane_mode_e;

    typedef struct packed {
        logic ph;
        logic pre;
    } phase_st_t;

endpackage

// File: rtl/clk_stop_phase.sv
module clk_stop_phase
    import clk_stop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic half_i,
    output logic ph_o
);

    phase_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (half_i) begin
            st_d.pre = ~st_q.pre;
            if (st_q.pre) begin
                st_d.ph = ~st_q.ph;
            end
        end else begin
            st_d.pre = 1'b0;
            st_d.ph  = ~st_q.ph;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_o = st_q.ph;

    AST_FULL_RATE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !half_i |=> (ph_o != $past(ph_o)));  // R8

endmodule

// File: rtl/clk_stop_cfg.sv
module clk_stop_cfg #(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdn_i,
    input  logic [N_OUT-1:0] out_en_i,
    input  logic [N_OUT-1:0] stop_mask_i,
    input  logic             stop_float_i,
    input  logic             pdn_float_i,
    input  logic             full_rate_i,
    output logic [N_OUT-1:0] out_en_o,
    output logic [N_OUT-1:0] stop_mask_o,
    output logic             stop_float_o,
    output logic             pdn_float_o,
    output logic             full_rate_o
);

    localparam int W = 2 * N_OUT + 3;

    logic [W-1:0] shadow_d, shadow_q;
    logic [W-1:0] incoming;

    assign incoming = {out_en_i, stop_mask_i, stop_float_i, pdn_float_i, full_rate_i};

    always_comb begin
        shadow_d = shadow_q;
        if (!pdn_i) begin
            shadow_d = incoming;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= {{N_OUT{1'b1}}, {N_OUT{1'b0}}, 1'b0, 1'b0, 1'b1};
        end else begin
            shadow_q <= shadow_d;
        end
    end

    assign {out_en_o, stop_mask_o, stop_float_o, pdn_float_o, full_rate_o} = shadow_q;

    AST_CFG_FROZEN_PDN: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_i |=> $stable(shadow_q));  // R7

endmodule

// File: rtl/clk_stop_lane.sv
module clk_stop_lane
    import clk_stop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ph_i,
    input  logic en_i,
    input  logic stop_i,
    input  logic pdn_i,
    input  logic stop_float_i,
    input  logic pdn_float_i,
    output logic t_o,
    output logic c_o,
    output logic oe_o
);

    lane_mode_e mode_d, mode_q, want;

    always_comb begin
        if (pdn_i) begin
            want = pdn_float_i ? MODE_FLOAT : MODE_HOLD;
        end else if (!en_i) begin
            want = MODE_FLOAT;
        end else if (stop_i) begin
            want = stop_float_i ? MODE_FLOAT : MODE_HOLD;
        end else begin
            want = MODE_RUN;
        end
        mode_d = mode_q;
        if (!ph_i) begin
            mode_d = want;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FLOAT;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        unique case (mode_q)
            MODE_RUN: begin
                t_o  = ph_i;
                c_o  = ~ph_i;
                oe_o = 1'b1;
            end
            MODE_HOLD: begin
                t_o  = 1'b1;
                c_o  = 1'b0;
                oe_o = 1'b1;
            end
            default: begin
                t_o  = 1'b0;
                c_o  = 1'b0;
                oe_o = 1'b0;
            end
        endcase
    end

    AST_MODE_SWITCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> !$past(ph_i));  // R5

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] oe_pin,
    input  logic             stop_n,
    input  logic             pdn_n,
    input  logic             pol_inv,
    input  logic             half_n,
    input  logic [N_OUT-1:0] cfg_out_en,
    input  logic [N_OUT-1:0] cfg_stop_mask,
    input  logic             cfg_stop_float,
    input  logic             cfg_pdn_float,
    input  logic             cfg_full_rate,
    output logic [N_OUT-1:0] clk_t,
    output logic [N_OUT-1:0] clk_c,
    output logic [N_OUT-1:0] clk_oe
);

    logic [N_OUT-1:0] pin_en;
    logic             stop_req;
    logic             pdn_req;
    logic             half_sel;
    logic             ph;

    logic [N_OUT-1:0] sh_en;
    logic [N_OUT-1:0] sh_mask;
    logic             sh_stop_float;
    logic             sh_pdn_float;
    logic             sh_full;

    // Pin polarity decode
    always_comb begin
        pin_en   = pol_inv ? ~oe_pin : oe_pin;
        stop_req = pol_inv ? stop_n : ~stop_n;
        pdn_req  = pol_inv ? pdn_n : ~pdn_n;
        half_sel = ~half_n | ~sh_full;
    end

    clk_stop_cfg #(.N_OUT(N_OUT)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .pdn_i        (pdn_req),
        .out_en_i     (cfg_out_en),
        .stop_mask_i  (cfg_stop_mask),
        .stop_float_i (cfg_stop_float),
        .pdn_float_i  (cfg_pdn_float),
        .full_rate_i  (cfg_full_rate),
        .out_en_o     (sh_en),
        .stop_mask_o  (sh_mask),
        .stop_float_o (sh_stop_float),
        .pdn_float_o  (sh_pdn_float),
        .full_rate_o  (sh_full)
    );

    clk_stop_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .half_i (half_sel),
        .ph_o   (ph)
    );

    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_lane
        clk_stop_lane u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .ph_i         (ph),
            .en_i         (pin_en[gi] & sh_en[gi]),
            .stop_i       (stop_req & sh_mask[gi]),
            .pdn_i        (pdn_req),
            .stop_float_i (sh_stop_float),
            .pdn_float_i  (sh_pdn_float),
            .t_o          (clk_t[gi]),
            .c_o          (clk_c[gi]),
            .oe_o         (clk_oe[gi])
        );
    end

    AST_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_req && $past(pdn_req) && $past(pdn_req, 2) && $past(pdn_req, 3)
         && $past(pdn_req, 4)) |-> $stable(clk_t));  // R6

    AST_FLOAT_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_oe == '0) |-> (clk_t == '0 && clk_c == '0));  // R2

endmodule

// File: tb/clk_stop_ctrl_tb.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] oe_pin = '1;
    logic stop_n = 1'b1, pdn_n = 1'b1, pol_inv = 1'b0, half_n = 1'b1;
    logic [N-1:0] cfg_out_en = '1, cfg_stop_mask = '0;
    logic cfg_stop_float = 1'b0, cfg_pdn_float = 1'b0, cfg_full_rate = 1'b1;
    logic [N-1:0] clk_t, clk_c, clk_oe;

    always #2 clk = ~clk;  // 250 MHz

    clk_stop_ctrl #(.N_OUT(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .oe_pin(oe_pin), .stop_n(stop_n), .pdn_n(pdn_n),
        .pol_inv(pol_inv), .half_n(half_n), .cfg_out_en(cfg_out_en),
        .cfg_stop_mask(cfg_stop_mask), .cfg_stop_float(cfg_stop_float),
        .cfg_pdn_float(cfg_pdn_float), .cfg_full_rate(cfg_full_rate),
        .clk_t(clk_t), .clk_c(clk_c), .clk_oe(clk_oe)
    );

    int n_chk = 0, n_fail = 0;
    string cur_req = "R9";
    bit finished = 0;

    // Reference model: 0 run, 1 driven hold, 2 float
    int m_mode [N];
    bit m_ph, m_pre;
    bit [N-1:0] m_en, m_mask;
    bit m_sf, m_pf, m_full;

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit [N-1:0] pe;
        bit sr, pr, half;
        int want;
        if (!rst_n) begin
            m_ph = 0; m_pre = 0;
            foreach (m_mode[i]) m_mode[i] = 2;
            m_en = '1; m_mask = '0; m_sf = 0; m_pf = 0; m_full = 1;
        end else begin
            pe = pol_inv ? ~oe_pin : oe_pin;
            sr = pol_inv ? stop_n : !stop_n;
            pr = pol_inv ? pdn_n : !pdn_n;
            for (int i = 0; i < N; i++) begin
                if (pr) want = m_pf ? 2 : 1;
                else if (!(pe[i] && m_en[i])) want = 2;
                else if (sr && m_mask[i]) want = m_sf ? 2 : 1;
                else want = 0;
                if (!m_ph) m_mode[i] = want;
            end
            half = !half_n || !m_full;
            if (half) begin
                if (m_pre) m_ph = !m_ph;
                m_pre = !m_pre;
            end else begin
                m_pre = 0;
                m_ph = !m_ph;
            end
            if (!pr) begin
                m_en = cfg_out_en; m_mask = cfg_stop_mask;
                m_sf = cfg_stop_float; m_pf = cfg_pdn_float; m_full = cfg_full_rate;
            end
        end
    end

    always @(negedge clk) begin
        logic [N-1:0] et, ec, eo;
        if (rst_n && !finished) begin
            for (int i = 0; i < N; i++) begin
                et[i] = (m_mode[i] == 0) ? m_ph : (m_mode[i] == 1);
                ec[i] = (m_mode[i] == 0) ? !m_ph : 1'b0;
                eo[i] = (m_mode[i] != 2);
            end
            chk(cur_req, clk_t, et);
            chk(cur_req, clk_c, ec);
            chk(cur_req, clk_oe, eo);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        logic [N-1:0] a, b;
        #1;
        step(3);
        // R9: reset state
        chk("R9", clk_oe, '0);
        chk("R9", clk_t, '0);
        rst_n = 1'b1;
        cur_req = "R8"; step(20);
        // R8: full-rate toggling seen directly
        a = clk_t; step(1); b = clk_t;
        chk("R8", b, ~a);
        chk("R8", clk_c, ~clk_t);
        half_n = 1'b0; step(20);
        half_n = 1'b1; cfg_full_rate = 1'b0; cur_req = "R7"; step(20);
        cfg_full_rate = 1'b1; step(10);
        cur_req = "R2";
        oe_pin = 8'b1111_1100; cfg_out_en = 8'b1111_1011; step(12);
        chk("R2", clk_oe, 8'b1111_1000);
        oe_pin = '1; cfg_out_en = '1; step(6);
        cur_req = "R3";
        cfg_stop_mask = 8'h0F; step(2);
        stop_n = 1'b0; step(10);
        chk("R4", clk_t & 8'h0F, 8'h0F);
        chk("R4", clk_c & 8'h0F, 8'h00);
        a = clk_t; step(1); b = clk_t;
        chk("R3", (a ^ b) & 8'hF0, 8'hF0);
        cfg_stop_float = 1'b1; cur_req = "R4"; step(10);
        chk("R4", clk_oe, 8'hF0);
        stop_n = 1'b1; cfg_stop_float = 1'b0; step(8);
        cur_req = "R5"; half_n = 1'b0; step(5);
        for (int k = 0; k < 6; k++) begin
            stop_n = 1'b0; step(3 + k);
            stop_n = 1'b1; step(2 + k);
        end
        half_n = 1'b1; step(6);
        cur_req = "R6";
        stop_n = 1'b0; oe_pin = 8'b1010_1010; pdn_n = 1'b0; step(10);
        chk("R6", clk_oe, '1);
        chk("R6", clk_t, '1);
        cur_req = "R7";
        cfg_pdn_float = 1'b1; cfg_stop_mask = 8'hFF; step(10);
        chk("R7", clk_oe, '1);
        pdn_n = 1'b1; stop_n = 1'b1; oe_pin = '1; step(10);
        cfg_pdn_float = 1'b1; step(2);
        pdn_n = 1'b0; step(10);
        chk("R6", clk_oe, '0);
        pdn_n = 1'b1; step(8);
        cur_req = "R1";
        pol_inv = 1'b1; oe_pin = '0; stop_n = 1'b0; pdn_n = 1'b0; cfg_stop_mask = 8'h0F; step(12);
        chk("R1", clk_oe, '1);
        stop_n = 1'b1; step(10);
        chk("R1", clk_t & 8'h0F, 8'h0F);
        oe_pin = 8'h01; step(10);
        chk("R1", clk_oe, 8'hFE);
        pdn_n = 1'b1; step(10);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule